// File: doc/BRIEF.md
# Dot-Matrix Panel Host Register File

This block is the host-facing register file of an eight-digit dot-matrix display controller. A host drives a slow strobe-based bus: active-low chip enable, write and read strobes, an attribute-select line, five address lines and an 8-bit data path. Every input except the read strobe passes through a two-stage synchroniser into the block's clock domain. A write commits exactly once, on the first cycle in which the synchronised chip enable and write strobe are both seen low. The read path is combinational from the synchronised address. Output enable follows the raw strobes, so the host's transceiver turns around at once.

Accesses are decoded into five regions. The regions are a per-digit character store, a per-digit attribute bit, a user glyph memory (16 glyphs of 7 rows of 5 dots), a glyph index register that selects which glyph the row accesses touch, and a control word. The block runs three timed sequences: reset recovery, the clear command and the self-test sequence. Scan logic reads the stored contents through flat export ports and through a combinational glyph lookup port. The data path is a plain register interface with no back-pressure. The host must keep address and data stable while chip enable is low and must leave chip enable high between accesses. The `busy` pin tells it when writes will be dropped.

Top module: `mdr_panel_regs`

## Requirements
- R1: A write takes effect only while chip enable and write strobe are both low. Chip enable alone, or write strobe alone, changes nothing. A committed write is visible within four clocks of the strobes falling.
- R2: Region decode works as follows. With bus_attr_n low the access goes to the attribute bits whatever bus_addr[4:3] holds. With bus_attr_n high, bus_addr[4:3] selects the region: 00 is the glyph index, 01 is a glyph row, 10 is the control word and 11 is the character store. bus_addr[2:0] selects digit 0 (leftmost, char_flat[7:0]) through digit 7.
- R3: A character entry stores all eight bits. Bit 7 is a tag: 0 marks an ASCII code in bits 6:0, and 1 marks a glyph number in bits 3:0. The entry reads back unchanged and appears on char_flat.
- R4: The glyph index keeps D3:D0 and reads back with the upper nibble zero. A glyph row write stores D4:D0 (D4 is the leftmost dot) into the row given by bus_addr[2:0] (0 to 6) of the indexed glyph. Row code 7 is neither stored nor readable: it reads as 0. scan_dots returns the stored row for scan_glyph/scan_row, and 0 for row 7.
- R5: An attribute write copies D0 into the addressed digit's bit. Reads return {7'b0, bit}, and flash_bits shows all eight bits.
- R6: A control write replaces bits 7, 6, 4 and 3:0 in one step. Bit 5 is the test result and ignores writes. brightness is bits 2:0, flash_enable is bit 3 and blink_enable is bit 4.
- R7: Writing control bit 7 as 1 holds busy high for exactly 3 clocks. After that, every character entry is 0x20, every attribute bit is 0 and bit 7 reads 0. The glyph memory, the glyph index and control bits 6:0 keep their values.
- R8: Reset sets every character to 0x20, clears the attributes and sets the control word to 0. It leaves the glyph memory and the glyph index untouched. busy stays high for 3 clocks after reset is released.
- R9: A write whose strobe is detected while busy is high is discarded.
- R10: bus_oe is high exactly while bus_ce_n and bus_rd_n are both low, following the pins without a clock. bus_dout is 0 whenever bus_oe is low.
- R11: Writing control bit 6 as 1 (with bit 7 at 0) starts self test. Bit 6 reads 1 and busy stays high for ST_CYCLES clocks. At the end, the characters are 0x20, the attributes are 0, the control word is 0x20 (bit 5 set means pass) and the glyph index is 0xF.
- R12: A control write with both bit 7 and bit 6 set runs only the clear. Bit 6 is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_attr_n | input | 1 | Low selects the attribute bits |
| bus_addr | input | 5 | Region and location address |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host, 0 when not enabled |
| bus_oe | output | 1 | Drive enable for the host data transceiver |
| busy | output | 1 | Recovery, clear or self test in progress |
| char_flat | output | N_DIGITS*8 | All character entries, digit 0 in the low byte |
| flash_bits | output | N_DIGITS | Attribute bit per digit |
| brightness | output | 3 | Brightness code (0 is full, 7 is blank) |
| flash_enable | output | 1 | Attribute flashing enabled |
| blink_enable | output | 1 | Whole-panel blink enabled |
| scan_glyph | input | log2(N_GLYPHS) | Glyph selected by the scan logic |
| scan_row | input | 3 | Row selected by the scan logic |
| scan_dots | output | N_COLS | Dots of that glyph row |

## Verification
A wrong region decode or digit index shows up on the first read-back: the value lands in a neighbour, which char_flat, flash_bits or scan_dots expose within four clocks of the strobe. A sequencer whose counter is off by one shows up as a busy window that is one clock short or long. If the sequencer fills at the wrong moment, the blank pattern is missing when busy falls. A lost bit-5 hold or a missing write guard during busy only appears on a later control read, or on scan_dots once self test ends. The sweeps therefore read after every such sequence.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  typedef enum logic [2:0] {RG_ATTR, RG_GIDX, RG_GROW, RG_CTRL, RG_CHAR} region_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RECOVER, SQ_CLEAR, SQ_TEST} seq_e;
  localparam logic [7:0] BLANK_CODE = 8'h20;
  localparam logic [7:0] TEST_PASS_WORD = 8'h20;
  localparam int CW_CLEAR  = 7;
  localparam int CW_TEST   = 6;
  localparam int CW_RESULT = 5;
  localparam int CW_BLINK  = 4;
  localparam int CW_FLASH  = 3;
endpackage

// File: rtl/mdr_bus_sync.sv
module mdr_bus_sync #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          attr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          s_attr_n,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_din,
  output logic          wr_fire
);
  localparam int W = 3 + AW + DW;

  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] last;
  logic ce_s, we_s, act, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      act_q <= 1'b0;
    end else begin
      pipe[0] <= {ce_n, we_n, attr_n, addr, din};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      act_q <= act;
    end
  end

  assign last     = pipe[STAGES-1];
  assign ce_s     = last[W-1];
  assign we_s     = last[W-2];
  assign s_attr_n = last[W-3];
  assign s_addr   = last[DW +: AW];
  assign s_din    = last[DW-1:0];
  assign act      = ~ce_s & ~we_s;
  assign wr_fire  = act & ~act_q;

  // R1: one commit per strobe pulse
  a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/mdr_decode.sv
module mdr_decode
  import mdr_pkg::*;
(
  input  logic       attr_n,
  input  logic [1:0] sel,
  output region_e    region
);
  always_comb begin
    if (!attr_n) begin
      region = RG_ATTR;
    end else begin
      case (sel)
        2'b00:   region = RG_GIDX;
        2'b01:   region = RG_GROW;
        2'b10:   region = RG_CTRL;
        default: region = RG_CHAR;
      endcase
    end
  end
endmodule

// File: rtl/mdr_sequencer.sv
module mdr_sequencer
  import mdr_pkg::*;
#(
  parameter int CLEAR_CYCLES   = 3,
  parameter int RECOVER_CYCLES = 3,
  parameter int TEST_CYCLES    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_clear,
  input  logic start_test,
  output logic busy,
  output logic clear_done,
  output logic test_done
);
  localparam int M1  = (CLEAR_CYCLES > RECOVER_CYCLES) ? CLEAR_CYCLES : RECOVER_CYCLES;
  localparam int MAXC = (TEST_CYCLES > M1) ? TEST_CYCLES : M1;
  localparam int CW  = $clog2(MAXC + 1);

  seq_e          state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_RECOVER;
      cnt   <= CW'(RECOVER_CYCLES - 1);
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_clear) begin
            state <= SQ_CLEAR;
            cnt   <= CW'(CLEAR_CYCLES - 1);
          end else if (start_test) begin
            state <= SQ_TEST;
            cnt   <= CW'(TEST_CYCLES - 1);
          end
        end
        default: begin
          if (cnt == '0) state <= SQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign busy       = (state != SQ_IDLE);
  assign clear_done = (state == SQ_CLEAR) && (cnt == '0);
  assign test_done  = (state == SQ_TEST)  && (cnt == '0);

  // R7: a clear request occupies the bus at once and releases it after finishing
  a_r7_clear_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_clear && !busy) |=> busy);
  a_r7_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clear_done |=> !busy);
  // R11: self test returns to idle when done
  a_r11_test_ends: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> !busy);
endmodule

// File: rtl/mdr_panel_regs.sv
module mdr_panel_regs
  import mdr_pkg::*;
#(
  parameter int N_DIGITS       = 8,
  parameter int N_GLYPHS       = 16,
  parameter int N_ROWS         = 7,
  parameter int N_COLS         = 5,
  parameter int SYNC_STAGES    = 2,
  parameter int CLEAR_CYCLES   = 3,
  parameter int RECOVER_CYCLES = 3,
  parameter int ST_CYCLES      = 64,
  localparam int GIW           = $clog2(N_GLYPHS),
  localparam int DIG_AW        = $clog2(N_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_ce_n,
  input  logic                  bus_we_n,
  input  logic                  bus_rd_n,
  input  logic                  bus_attr_n,
  input  logic [4:0]            bus_addr,
  input  logic [7:0]            bus_din,
  output logic [7:0]            bus_dout,
  output logic                  bus_oe,
  output logic                  busy,
  output logic [N_DIGITS*8-1:0] char_flat,
  output logic [N_DIGITS-1:0]   flash_bits,
  output logic [2:0]            brightness,
  output logic                  flash_enable,
  output logic                  blink_enable,
  input  logic [GIW-1:0]        scan_glyph,
  input  logic [2:0]            scan_row,
  output logic [N_COLS-1:0]     scan_dots
);
  localparam int GRAM_DEPTH = N_GLYPHS * N_ROWS;
  localparam int GRAM_AW    = $clog2(GRAM_DEPTH + 8);

  logic           s_attr_n, wr_fire, wr_ok;
  logic [4:0]     s_addr;
  logic [7:0]     s_din;
  region_e        region;
  logic           clear_done, test_done;
  logic           we_char, we_attr, we_gidx, we_grow, we_ctrl;
  logic           start_clear, start_test;
  logic [DIG_AW-1:0] dig;
  logic [2:0]     loc;
  logic           row_ok, scan_row_ok;
  logic [GRAM_AW-1:0] g_addr, sc_addr;
  logic [7:0]     rdata;

  logic [7:0]        char_q [N_DIGITS];
  logic [N_DIGITS-1:0] attr_q;
  logic [7:0]        ctrl_q;
  logic [GIW-1:0]    gidx_q;
  logic [N_COLS-1:0] glyph_q [GRAM_DEPTH];

  mdr_bus_sync #(.AW(5), .DW(8), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(bus_ce_n), .we_n(bus_we_n),
    .attr_n(bus_attr_n), .addr(bus_addr), .din(bus_din),
    .s_attr_n(s_attr_n), .s_addr(s_addr), .s_din(s_din), .wr_fire(wr_fire)
  );

  mdr_decode u_dec (.attr_n(s_attr_n), .sel(s_addr[4:3]), .region(region));

  mdr_sequencer #(
    .CLEAR_CYCLES(CLEAR_CYCLES), .RECOVER_CYCLES(RECOVER_CYCLES), .TEST_CYCLES(ST_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_clear(start_clear), .start_test(start_test),
    .busy(busy), .clear_done(clear_done), .test_done(test_done)
  );

  assign loc     = s_addr[2:0];
  assign dig     = s_addr[DIG_AW-1:0];
  assign row_ok  = (int'(loc) < N_ROWS);
  assign g_addr  = GRAM_AW'(int'(gidx_q) * N_ROWS + int'(loc));
  assign sc_addr = GRAM_AW'(int'(scan_glyph) * N_ROWS + int'(scan_row));
  assign scan_row_ok = (int'(scan_row) < N_ROWS);

  assign wr_ok   = wr_fire & ~busy;
  assign we_char = wr_ok && (region == RG_CHAR);
  assign we_attr = wr_ok && (region == RG_ATTR);
  assign we_gidx = wr_ok && (region == RG_GIDX);
  assign we_grow = wr_ok && (region == RG_GROW);
  assign we_ctrl = wr_ok && (region == RG_CTRL);

  assign start_clear = we_ctrl & s_din[CW_CLEAR];
  assign start_test  = we_ctrl & s_din[CW_TEST] & ~s_din[CW_CLEAR];

  // character, attribute and control storage (cleared by reset)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DIGITS; i++) char_q[i] <= BLANK_CODE;
      attr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (clear_done || test_done) begin
        for (int i = 0; i < N_DIGITS; i++) char_q[i] <= BLANK_CODE;
        attr_q <= '0;
      end else begin
        if (we_char) char_q[dig] <= s_din;
        if (we_attr) attr_q[dig] <= s_din[0];
      end
      if (test_done) begin
        ctrl_q <= TEST_PASS_WORD;
      end else if (clear_done) begin
        ctrl_q[CW_CLEAR] <= 1'b0;
      end else if (we_ctrl) begin
        ctrl_q <= {s_din[CW_CLEAR], s_din[CW_TEST] & ~s_din[CW_CLEAR],
                   ctrl_q[CW_RESULT], s_din[CW_BLINK:0]};
      end
    end
  end

  // glyph index and glyph memory keep their contents through reset
  always_ff @(posedge clk) begin
    if (test_done)    gidx_q <= '1;
    else if (we_gidx) gidx_q <= s_din[GIW-1:0];
  end

  always_ff @(posedge clk) begin
    if (we_grow && row_ok) glyph_q[g_addr] <= s_din[N_COLS-1:0];
  end

  always_comb begin
    case (region)
      RG_ATTR: rdata = {7'b0, attr_q[dig]};
      RG_GIDX: rdata = {{(8-GIW){1'b0}}, gidx_q};
      RG_GROW: rdata = row_ok ? {{(8-N_COLS){1'b0}}, glyph_q[g_addr]} : 8'h00;
      RG_CTRL: rdata = ctrl_q;
      default: rdata = char_q[dig];
    endcase
  end

  assign bus_oe   = ~bus_ce_n & ~bus_rd_n;
  assign bus_dout = bus_oe ? rdata : 8'h00;

  generate
    for (genvar g = 0; g < N_DIGITS; g++) begin : g_export
      assign char_flat[8*g +: 8] = char_q[g];
    end
  endgenerate

  assign flash_bits   = attr_q;
  assign brightness   = ctrl_q[2:0];
  assign flash_enable = ctrl_q[CW_FLASH];
  assign blink_enable = ctrl_q[CW_BLINK];
  assign scan_dots    = scan_row_ok ? glyph_q[sc_addr] : '0;

  // R2: at most one region accepts a write
  a_r2_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_char, we_attr, we_gidx, we_grow, we_ctrl}));
  // R9: a strobe seen while busy leaves the glyph index alone
  a_r9_busy_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_fire && !clear_done && !test_done) |=> $stable(gidx_q));
  // R7: the clear bit is only ever set while the clear runs
  a_r7_bit7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CW_CLEAR] |-> busy);
  // R5: a finished clear or test leaves no attribute set
  a_r5_fill_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_done || test_done) |=> (attr_q == '0));
  // R6: host writes never move the result bit
  a_r6_bit5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we_ctrl |=> (ctrl_q[CW_RESULT] == $past(ctrl_q[CW_RESULT])));
endmodule

// File: tb/mdr_panel_regs_test.sv
`timescale 1ns/1ps
module mdr_panel_regs_test;
  localparam int ND = 8;
  localparam int ST = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_rd_n = 1'b1, bus_attr_n = 1'b1;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic bus_oe, busy, flash_enable, blink_enable;
  logic [ND*8-1:0] char_flat;
  logic [ND-1:0] flash_bits;
  logic [2:0] brightness;
  logic [3:0] scan_glyph = '0;
  logic [2:0] scan_row = '0;
  logic [4:0] scan_dots;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  mdr_panel_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_rd_n(bus_rd_n), .bus_attr_n(bus_attr_n), .bus_addr(bus_addr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .busy(busy),
    .char_flat(char_flat), .flash_bits(flash_bits), .brightness(brightness),
    .flash_enable(flash_enable), .blink_enable(blink_enable),
    .scan_glyph(scan_glyph), .scan_row(scan_row), .scan_dots(scan_dots)
  );

  function automatic logic [4:0] gd(input int g, input int r);
    return 5'((g * 7 + r * 3 + 1) % 32);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic attr, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_attr_n = attr; bus_addr = a; bus_din = d;
    bus_ce_n = 1'b0; bus_we_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_ce_n = 1'b1; bus_we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic attr, input logic [4:0] a, output logic [7:0] q);
    @(negedge clk);
    bus_attr_n = attr; bus_addr = a;
    bus_ce_n = 1'b0; bus_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    q = bus_dout;
    bus_ce_n = 1'b1; bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_timed(input logic [7:0] d, input int window, output int bc);
    bc = 0;
    @(negedge clk);
    bus_attr_n = 1'b1; bus_addr = 5'b10_000; bus_din = d;
    bus_ce_n = 1'b0; bus_we_n = 1'b0;
    for (int k = 0; k < window; k++) begin
      @(negedge clk);
      if (busy) bc++;
      if (k == 3) begin bus_ce_n = 1'b1; bus_we_n = 1'b1; end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_blank(input string tag);
    for (int i = 0; i < ND; i++) chk(tag, char_flat[8*i +: 8], 8'h20);
    chk(tag, flash_bits, '0);
  endtask

  initial begin
    #1_000_000;
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int bc;
    logic [7:0] d;

    // R8: reset state and recovery window
    repeat (3) @(negedge clk);
    chk("R8 busy in reset", busy, 1'b1);
    chk_blank("R8 reset blank");
    chk("R8 ctrl outs", {blink_enable, flash_enable, brightness}, 5'h0);
    rst_n = 1'b1;
    @(negedge clk); chk("R8 recover1", busy, 1'b1);
    @(negedge clk); chk("R8 recover2", busy, 1'b1);
    @(negedge clk); chk("R8 recover3", busy, 1'b0);

    // R2, R3: character store sweep
    for (int i = 0; i < ND; i++) wr(1'b1, {2'b11, 3'(i)}, 8'((i * 37 + 5) | ((i % 2) << 7)));
    for (int i = 0; i < ND; i++) begin
      d = 8'((i * 37 + 5) | ((i % 2) << 7));
      rd(1'b1, {2'b11, 3'(i)}, q);
      chk("R3 char readback", q, d);
      chk("R2 char digit position", char_flat[8*i +: 8], d);
    end

    // R1: partial strobes do nothing
    @(negedge clk);
    bus_attr_n = 1'b1; bus_addr = 5'b11_010; bus_din = 8'h55;
    bus_ce_n = 1'b0; bus_we_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_ce_n = 1'b1; bus_we_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_we_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 partial strobe", char_flat[8*2 +: 8], 8'((2 * 37 + 5)));
    wr(1'b1, 5'b11_010, 8'h55);
    chk("R1 full strobe", char_flat[8*2 +: 8], 8'h55);

    // R5, R2: attribute bits with A4:A3 varied
    for (int i = 0; i < ND; i++) wr(1'b0, {2'(i), 3'(i)}, 8'hFE | 8'((8'hA5 >> i) & 1));
    chk("R5 attr bits", flash_bits, 8'hA5);
    for (int i = 0; i < ND; i++) begin
      rd(1'b0, {2'(i + 1), 3'(i)}, q);
      chk("R5 attr readback", q, 8'((8'hA5 >> i) & 1));
    end

    // R4: glyph memory sweep
    for (int g = 0; g < 16; g++) begin
      wr(1'b1, 5'b00_000, 8'hF0 | 8'(g));
      for (int r = 0; r < 7; r++) wr(1'b1, {2'b01, 3'(r)}, 8'hE0 | 8'(gd(g, r)));
      wr(1'b1, 5'b01_111, 8'h1F);
      rd(1'b1, 5'b00_000, q); chk("R4 index readback", q, 8'(g));
      rd(1'b1, {2'b01, 3'(g % 7)}, q); chk("R4 row readback", q, 8'(gd(g, g % 7)));
      rd(1'b1, 5'b01_111, q); chk("R4 row7 reads zero", q, 8'h00);
    end
    for (int g = 0; g < 16; g++) begin
      for (int r = 0; r < 8; r++) begin
        scan_glyph = 4'(g); scan_row = 3'(r); #1;
        chk("R4 scan port", scan_dots, (r < 7) ? gd(g, r) : 5'h0);
      end
    end

    // R6: control word fields, bit 5 read-only
    wr(1'b1, 5'b10_000, 8'h3B);
    rd(1'b1, 5'b10_000, q); chk("R6 ctrl readback", q, 8'h1B);
    chk("R6 fields", {blink_enable, flash_enable, brightness}, {1'b1, 1'b1, 3'd3});
    wr(1'b1, 5'b10_101, 8'h04);
    rd(1'b1, 5'b10_000, q); chk("R6 ctrl second", q, 8'h04);
    chk("R6 fields second", {blink_enable, flash_enable, brightness}, {1'b0, 1'b0, 3'd4});

    // R7: clear command
    wr_timed(8'h85, 12, bc);
    chk("R7 busy length", bc, 3);
    chk_blank("R7 cleared");
    rd(1'b1, 5'b10_000, q); chk("R7 ctrl after clear", q, 8'h05);
    rd(1'b1, 5'b00_000, q); chk("R7 index kept", q, 8'h0F);
    scan_glyph = 4'd4; scan_row = 3'd2; #1;
    chk("R7 glyph kept", scan_dots, gd(4, 2));

    // R11: self test
    wr(1'b1, 5'b11_000, 8'h41);
    wr(1'b0, 5'b00_001, 8'h01);
    wr(1'b1, 5'b00_000, 8'h03);
    wr_timed(8'h47, 80, bc);
    chk("R11 busy length", bc, ST);
    chk_blank("R11 blank after test");
    rd(1'b1, 5'b10_000, q); chk("R11 ctrl result", q, 8'h20);
    rd(1'b1, 5'b00_000, q); chk("R11 index ones", q, 8'h0F);
    chk("R11 brightness", brightness, 3'd0);
    wr(1'b1, 5'b10_000, 8'h00);
    rd(1'b1, 5'b10_000, q); chk("R6 bit5 survives write", q, 8'h20);

    // R9, R11: writes while busy are dropped; bit 6 visible during test
    wr(1'b1, 5'b00_000, 8'h03);
    wr(1'b1, 5'b10_000, 8'h40);
    chk("R11 busy running", busy, 1'b1);
    rd(1'b1, 5'b10_000, q); chk("R11 bit6 during test", q, 8'h60);
    wr(1'b1, 5'b01_000, 8'(~gd(3, 0)));
    chk("R9 still busy", busy, 1'b1);
    while (busy) @(negedge clk);
    scan_glyph = 4'd3; scan_row = 3'd0; #1;
    chk("R9 write dropped", scan_dots, gd(3, 0));

    // R12: both bits set runs only the clear
    wr_timed(8'hC2, 12, bc);
    chk("R12 busy length", bc, 3);
    rd(1'b1, 5'b10_000, q); chk("R12 ctrl", q, 8'h22);

    // R10: output enable follows raw strobes
    @(negedge clk);
    bus_attr_n = 1'b1; bus_addr = 5'b10_000;
    bus_ce_n = 1'b1; bus_rd_n = 1'b0; #1;
    chk("R10 ce high", {bus_oe, bus_dout}, 9'h000);
    bus_ce_n = 1'b0; bus_rd_n = 1'b1; #1;
    chk("R10 rd high", {bus_oe, bus_dout}, 9'h000);
    bus_rd_n = 1'b0; #1;
    chk("R10 both low", {bus_oe, bus_dout}, {1'b1, 8'h22});
    bus_ce_n = 1'b1; #1;
    chk("R10 release", bus_oe, 1'b0);
    bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset keeps glyph memory and index
    wr(1'b1, 5'b11_001, 8'h7A);
    wr(1'b0, 5'b00_101, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_blank("R8 second reset");
    rd(1'b1, 5'b10_000, q); chk("R8 ctrl zero", q, 8'h00);
    rd(1'b1, 5'b00_000, q); chk("R8 index kept", q, 8'h0F);
    scan_glyph = 4'd7; scan_row = 3'd3; #1;
    chk("R8 glyph kept", scan_dots, gd(7, 3));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule